// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block keeps a 16-bit up-counter that either guards the system as a watchdog or runs as a periodic interval timer. Software reaches it through one 16-bit register port. A write changes the 8-bit control field only when its upper byte carries the write key. A write with any other upper byte is treated as tampering and raises a system reset request. A read always returns a fixed read key in the upper byte and the control field in the lower byte. The counter itself is never visible on the register port.

The counter advances on one of two single-cycle tick enables, fast or slow, both in the block's clock domain. Its expiry period is one of four powers of two chosen by a tap select. In watchdog mode an expiry requests a system reset. In interval mode an expiry raises an interrupt request. A status flag records either kind of event, and a synchronous PUC pulse leaves that flag alone so that software can tell what caused a restart. The block also conditions the external reset/NMI pin. The pin works either as a level-sensitive reset or as an edge-triggered non-maskable interrupt, with the active edge selectable.

Top module: `wdt_guard`

## Requirements
- R1: After the asynchronous reset `rd_data_o` reads 16'h6900. `sys_rst_req_o`, `flag_o`, `irq_o` and `nmi_o` are all low.
- R2: A write whose bits [15:8] equal 8'h5A loads the control field from bits [7:0]. A write with any other upper byte leaves the control field unchanged. On the cycle after such a bad-key write, `sys_rst_req_o` is high for one cycle and `flag_o` is set.
- R3: A read returns 8'h69 in bits [15:8] and the control field in bits [7:0], with this layout: [1:0] tap select, [2] source select, [3] clear (always reads 0), [4] mode, [5] pin function, [6] NMI edge, [7] hold.
- R4: Tap select 00, 01, 10 and 11 give expiry after 2^15, 2^13, 2^9 and 2^6 ticks. On expiry the counter returns to zero.
- R5: When source select is 0 the counter advances on `fast_tick_i`. When it is 1 the counter advances on `slow_tick_i`.
- R6: An accepted write with bit 3 set restarts the counter at zero. This takes priority over a tick in the same cycle.
- R7: In watchdog mode (mode bit 0), an expiry makes `sys_rst_req_o` pulse high for one cycle and sets `flag_o` on the following cycle.
- R8: In interval mode (mode bit 1), an expiry sets `flag_o` and does not request a reset. `irq_o` is high exactly when `flag_o`, `irq_en_i` and the mode bit are all high.
- R9: `irq_ack_i` clears `flag_o` on the next cycle. If an event sets the flag in the same cycle, the set wins.
- R10: While the hold bit is 1 the counter keeps its value. It resumes from that value when hold is cleared.
- R11: When the pin function bit is 0, `pin_reset_o` is high exactly while `pin_i` is low, and `nmi_o` stays low.
- R12: When the pin function bit is 1, `pin_reset_o` stays low. `nmi_o` is high for one cycle after a rising edge of `pin_i` if the edge bit is 0, or after a falling edge if the edge bit is 1.
- R13: A PUC pulse clears the control field and the counter. It leaves `flag_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| puc_i | input | 1 | Synchronous PUC pulse |
| fast_tick_i | input | 1 | Fast clock-source enable |
| slow_tick_i | input | 1 | Slow clock-source enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data: key in [15:8], control in [7:0] |
| rd_data_o | output | 16 | Read data: read key and control field |
| irq_en_i | input | 1 | Interval interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge; clears the flag |
| pin_i | input | 1 | Reset/NMI pin level, already synchronised |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| flag_o | output | 1 | Watchdog/interval event flag |
| irq_o | output | 1 | Interval interrupt request |
| nmi_o | output | 1 | One-cycle NMI pulse |
| pin_reset_o | output | 1 | Level reset from the pin |

## Verification
Several rules are checked on every cycle:
- a bad-key write always raises the reset request and the flag;
- the control field never moves without a write or PUC;
- a held counter never moves;
- the interrupt is gated correctly;
- the pin behaves as a level reset or an edge NMI.

Other behaviour can only be shown by the scenarios: the exact expiry periods for each tap and clock source, resuming after hold from the kept count, and a clear write restarting a period mid-way. The bench's cycle model compares all outputs on every clock through those scenarios.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int          REG_W  = 16;
  localparam logic [7:0]  WR_KEY = 8'h5A;
  localparam logic [7:0]  RD_KEY = 8'h69;

  typedef struct packed {
    logic       hold;
    logic       nmi_fall;
    logic       pin_nmi;
    logic       ivl_mode;
    logic       clr;
    logic       src_slow;
    logic [1:0] tap;
  } wctl_t;
endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
  import wdt_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             puc_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output wctl_t            ctl_o,
  output logic             clr_o,
  output logic             key_bad_o
);
  wctl_t ctl_q, ctl_d;
  logic  key_ok, accept;

  always_comb begin
    key_ok    = (wr_data_i[REG_W-1:8] == WR_KEY);
    accept    = wr_en_i & key_ok;
    key_bad_o = wr_en_i & ~key_ok;
    clr_o     = accept & wr_data_i[3];
    ctl_d     = ctl_q;
    if (puc_i) begin
      ctl_d = '0;
    end else if (accept) begin
      ctl_d     = wctl_t'(wr_data_i[7:0]);
      ctl_d.clr = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CW   = 16,
  parameter int TAP0 = 15,
  parameter int TAP1 = 13,
  parameter int TAP2 = 9,
  parameter int TAP3 = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          puc_i,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [1:0]    tap_i,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);
  localparam int NTAP       = 4;
  localparam int TAPS[NTAP] = '{TAP0, TAP1, TAP2, TAP3};

  logic [CW-1:0] mask [NTAP];
  logic [CW-1:0] sel_mask, cnt_q, cnt_d;
  logic          at_tap;

  for (genvar g = 0; g < NTAP; g++) begin : g_mask
    assign mask[g] = CW'((64'd1 << TAPS[g]) - 64'd1);
  end

  always_comb begin
    sel_mask = mask[tap_i];
    at_tap   = ((cnt_q & sel_mask) == sel_mask);
    expire_o = run_i & at_tap & ~clr_i & ~puc_i;
    cnt_d    = cnt_q;
    if (puc_i || clr_i)  cnt_d = '0;
    else if (expire_o)   cnt_d = '0;
    else if (run_i)      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_pin_ctl.sv
module wdt_pin_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pin_nmi_i,
  input  logic nmi_fall_i,
  output logic pin_reset_o,
  output logic nmi_o
);
  logic pin_q;
  logic rise, fall;

  always_comb begin
    rise        = pin_i & ~pin_q;
    fall        = ~pin_i & pin_q;
    pin_reset_o = ~pin_nmi_i & ~pin_i;
    nmi_o       = pin_nmi_i & (nmi_fall_i ? fall : rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_i;
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             puc_i,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             irq_en_i,
  input  logic             irq_ack_i,
  input  logic             pin_i,
  output logic             sys_rst_req_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             pin_reset_o
);
  wctl_t         ctl;
  logic          clr, key_bad, tick, run, expire;
  logic [CW-1:0] cnt_w;
  logic          flag_q, flag_d, rq_q, rq_d;

  wdt_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .puc_i(puc_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .ctl_o(ctl), .clr_o(clr), .key_bad_o(key_bad)
  );

  always_comb begin
    tick = ctl.src_slow ? slow_tick_i : fast_tick_i;
    run  = tick & ~ctl.hold;
  end

  wdt_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .puc_i(puc_i), .clr_i(clr), .run_i(run),
    .tap_i(ctl.tap), .expire_o(expire), .cnt_o(cnt_w)
  );

  wdt_pin_ctl u_pin (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_nmi_i(ctl.pin_nmi),
    .nmi_fall_i(ctl.nmi_fall), .pin_reset_o(pin_reset_o), .nmi_o(nmi_o)
  );

  always_comb begin
    rq_d   = key_bad | (expire & ~ctl.ivl_mode);
    flag_d = flag_q;
    if (key_bad || expire) flag_d = 1'b1;
    else if (irq_ack_i)    flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rq_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      rq_q   <= rq_d;
    end
  end

  assign rd_data_o     = {RD_KEY, ctl};
  assign sys_rst_req_o = rq_q;
  assign flag_o        = flag_q;
  assign irq_o         = flag_q & irq_en_i & ctl.ivl_mode;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          puc_i,
  input logic          wr_en_i,
  input logic [15:0]   wr_data_i,
  input logic [15:0]   rd_data_o,
  input logic          irq_en_i,
  input logic          irq_ack_i,
  input logic          pin_i,
  input logic          sys_rst_req_o,
  input logic          flag_o,
  input logic          irq_o,
  input logic          nmi_o,
  input logic          pin_reset_o,
  input logic [CW-1:0] cnt
);
  logic bad_wr;
  assign bad_wr = wr_en_i && (wr_data_i[15:8] != 8'h5A);

  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> sys_rst_req_o && flag_o);
  p_bad_key_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr && !puc_i |=> $stable(rd_data_o));
  p_ctl_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i && !puc_i |=> $stable(rd_data_o));
  p_rst_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |-> flag_o);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o && irq_en_i && rd_data_o[4]);
  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(irq_ack_i));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[7] && !wr_en_i && !puc_i |=> $stable(cnt));
  p_pin_lvl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data_o[5] |-> (pin_reset_o == !pin_i) && !nmi_o);
  p_nmi_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> rd_data_o[5] && !pin_reset_o && (pin_i != $past(pin_i)));
  p_puc_r13: assert property (@(posedge clk) disable iff (!rst_n)
    puc_i |=> rd_data_o[7:0] == 8'h00);
  p_puc_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    puc_i && flag_o |=> flag_o);
endmodule

bind wdt_guard wdt_guard_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .puc_i(puc_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_en_i(irq_en_i),
  .irq_ack_i(irq_ack_i), .pin_i(pin_i), .sys_rst_req_o(sys_rst_req_o),
  .flag_o(flag_o), .irq_o(irq_o), .nmi_o(nmi_o), .pin_reset_o(pin_reset_o),
  .cnt(cnt_w)
);

// File: tb/sim_wdt_guard.sv
`timescale 1ns/1ps
module sim_wdt_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        puc = 1'b0, fast = 1'b1, slow = 1'b0, w = 1'b0;
  logic [15:0] wd = 16'h0;
  logic        ien = 1'b0, ack = 1'b0, pin = 1'b1;
  logic [15:0] rd;
  logic        rq, flag, irq, nmi, prst;

  int vecs = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic snap_nmi, snap_prst;

  // reference state
  logic [15:0] m_cnt;
  logic [7:0]  m_ctl;
  logic        m_flag, m_rq, m_pinq;

  always #5 clk = ~clk;

  wdt_guard u0 (
    .clk(clk), .rst_n(rst_n), .puc_i(puc), .fast_tick_i(fast),
    .slow_tick_i(slow), .wr_en_i(w), .wr_data_i(wd), .rd_data_o(rd),
    .irq_en_i(ien), .irq_ack_i(ack), .pin_i(pin), .sys_rst_req_o(rq),
    .flag_o(flag), .irq_o(irq), .nmi_o(nmi), .pin_reset_o(prst)
  );

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int tap_bits(logic [1:0] t);
    case (t)
      2'b00: return 15;
      2'b01: return 13;
      2'b10: return 9;
      default: return 6;
    endcase
  endfunction

  task automatic compare_all();
    logic exp_nmi;
    exp_nmi = m_ctl[5] && (m_ctl[6] ? (m_pinq && !pin) : (!m_pinq && pin));
    chk("R3 rd_data", rd, {8'h69, m_ctl});
    chk("R7 sys_rst_req", {15'd0, rq}, {15'd0, m_rq});
    chk("R9 flag", {15'd0, flag}, {15'd0, m_flag});
    chk("R8 irq", {15'd0, irq}, {15'd0, m_flag && ien && m_ctl[4]});
    chk("R12 nmi", {15'd0, nmi}, {15'd0, exp_nmi});
    chk("R11 pin_reset", {15'd0, prst}, {15'd0, !m_ctl[5] && !pin});
  endtask

  task automatic model_step();
    logic key_bad, accept, clr, tick, run, ex;
    logic [15:0] mask;
    key_bad = w && (wd[15:8] != 8'h5A);
    accept  = w && !key_bad;
    clr     = accept && wd[3];
    tick    = m_ctl[2] ? slow : fast;
    run     = tick && !m_ctl[7];
    mask    = 16'((32'd1 << tap_bits(m_ctl[1:0])) - 1);
    ex      = run && !puc && !clr && ((m_cnt & mask) == mask);
    m_rq    = key_bad || (ex && !m_ctl[4]);
    if (key_bad || ex) m_flag = 1'b1;
    else if (ack)      m_flag = 1'b0;
    if (puc || clr)    m_cnt = 16'd0;
    else if (ex)       m_cnt = 16'd0;
    else if (run)      m_cnt = m_cnt + 16'd1;
    if (puc)           m_ctl = 8'h00;
    else if (accept)   m_ctl = wd[7:0] & 8'hF7;
    m_pinq = pin;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slow = (cyc % 4 == 0);
      cyc++;
      #1;
      snap_nmi  = nmi;
      snap_prst = prst;
      compare_all();
      @(posedge clk);
      model_step();
      #2;
    end
  endtask

  task automatic wr(logic [15:0] d);
    w = 1'b1; wd = d;
    run(1);
    w = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired got running exp finished");
    finish_run();
  end

  initial begin
    m_cnt = 0; m_ctl = 0; m_flag = 0; m_rq = 0; m_pinq = 1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    chk("R1 rd_data", rd, 16'h6900);
    chk("R1 req/flag/irq/nmi", {12'd0, rq, flag, irq, nmi}, 16'd0);

    // R4 R7: default tap 2^15, watchdog mode
    run(32767);
    chk("R4 no early expiry", {15'd0, rq}, 16'd0);
    run(1);
    chk("R7 reset request", {15'd0, rq}, 16'd1);
    chk("R7 flag set", {15'd0, flag}, 16'd1);
    run(1);
    chk("R7 single pulse", {15'd0, rq}, 16'd0);

    // R3 R8: interval mode, tap 2^6, clear; ack clears old flag
    ien = 1'b1; ack = 1'b1;
    wr(16'h5A1B);
    ack = 1'b0;
    chk("R3 readback clear bit 0", rd, 16'h6913);
    chk("R9 ack cleared", {15'd0, flag}, 16'd0);
    run(63);
    chk("R4 tap 2^6 not yet", {15'd0, flag}, 16'd0);
    run(1);
    chk("R8 interval flag", {15'd0, flag}, 16'd1);
    chk("R8 irq", {15'd0, irq}, 16'd1);
    chk("R8 no reset", {15'd0, rq}, 16'd0);
    ack = 1'b1; run(1); ack = 1'b0;
    chk("R9 flag cleared", {15'd0, flag}, 16'd0);
    chk("R9 irq dropped", {15'd0, irq}, 16'd0);

    // R10 hold keeps count
    wr(16'h5A1B);
    run(30);
    wr(16'h5A93);
    run(100);
    chk("R10 held no expiry", {15'd0, flag}, 16'd0);
    wr(16'h5A13);
    run(32);
    chk("R10 resumed count", {15'd0, flag}, 16'd0);
    run(1);
    chk("R10 expiry from kept value", {15'd0, flag}, 16'd1);
    ack = 1'b1; run(1); ack = 1'b0;

    // R5 slow source
    wr(16'h5A1F);
    run(200);
    chk("R5 slow not yet", {15'd0, flag}, 16'd0);
    run(100);
    chk("R5 slow expiry", {15'd0, flag}, 16'd1);
    ien = 1'b0; run(1);
    chk("R8 irq masked", {15'd0, irq}, 16'd0);
    chk("R8 flag kept", {15'd0, flag}, 16'd1);
    ien = 1'b1;
    ack = 1'b1; run(1); ack = 1'b0;

    // R6 clear restarts, R4 tap 2^9
    wr(16'h5A1A);
    run(300);
    wr(16'h5A1A);
    run(511);
    chk("R6 restart", {15'd0, flag}, 16'd0);
    run(1);
    chk("R4 tap 2^9", {15'd0, flag}, 16'd1);
    ack = 1'b1; run(1); ack = 1'b0;

    // R4 tap 2^13
    wr(16'h5A19);
    run(8191);
    chk("R4 tap 2^13 not yet", {15'd0, flag}, 16'd0);
    run(1);
    chk("R4 tap 2^13", {15'd0, flag}, 16'd1);
    ack = 1'b1; run(1); ack = 1'b0;

    // R2 bad key
    wr(16'hA51B);
    chk("R2 bad key reset", {15'd0, rq}, 16'd1);
    chk("R2 bad key flag", {15'd0, flag}, 16'd1);
    chk("R2 ctl unchanged", rd, 16'h6911);
    run(1);
    chk("R2 pulse ends", {15'd0, rq}, 16'd0);

    // R13 PUC
    puc = 1'b1; run(1); puc = 1'b0;
    chk("R13 ctl cleared", rd, 16'h6900);
    chk("R13 flag kept", {15'd0, flag}, 16'd1);

    // R11 pin as level reset
    pin = 1'b0; run(1);
    chk("R11 pin reset", {15'd0, prst}, 16'd1);
    pin = 1'b1; run(1);
    chk("R11 pin released", {15'd0, prst}, 16'd0);

    // R12 NMI edges
    wr(16'h5A20);
    pin = 1'b0; run(1);
    chk("R12 no reset in nmi mode", {15'd0, snap_prst}, 16'd0);
    chk("R12 falling ignored", {15'd0, snap_nmi}, 16'd0);
    pin = 1'b1; run(1);
    chk("R12 rising nmi", {15'd0, snap_nmi}, 16'd1);
    run(1);
    chk("R12 nmi one cycle", {15'd0, snap_nmi}, 16'd0);
    wr(16'h5A60);
    pin = 1'b0; run(1);
    chk("R12 falling nmi", {15'd0, snap_nmi}, 16'd1);
    pin = 1'b1; run(1);
    chk("R12 rising ignored", {15'd0, snap_nmi}, 16'd0);
    run(4);
    finish_run();
  end
endmodule